// File: doc/BRIEF.md
# Indirect Register Access Window

This block is a small I/O-space front end that reaches a large memory-mapped register file through a pair of ports. The host first writes a target register offset into an address port. It then reads or writes a data port, and the block turns that access into a transaction on the internal register bus. The window is 32 bytes wide, and every access to it is a full 32-bit little-endian dword.

The latched offset is sorted into one of four ranges: register, undefined, flash and unknown. Only the register range reaches the back-end bus, through a valid/ready request and a read-response strobe. An access to any other range is dropped: a read returns zero and a write changes nothing. For each dropped access the block raises a one-cycle status strobe that carries a 2-bit code naming the range.

The register file and the flash region lie outside the block. A host read that goes to the bus completes only when the back end has answered.

Top module: `iowin_top`

## Requirements
- R1: The address port is the dword at window offset 0x0. A full-strobe write there stores all 32 bits, and a read there returns the stored value unchanged. The stored value is zero after reset.
- R2: The data port is the dword at window offset 0x4. When the latched value is below 0x1FFFF, a full-strobe data-port access is forwarded on the register bus. `rb_addr` equals the low 17 bits of the latched value, `rb_write` equals the host direction, and on a write `rb_wdata` equals the host data.
- R3: A forwarded read raises `io_rvalid` only in the cycle after `rb_rvalid` is sampled high, and `io_rdata` then carries `rb_rdata`. A response in the handshake cycle itself is accepted.
- R4: `rb_valid` stays high, with address, direction and write data stable, until `rb_ready` is sampled. `io_ready` is low while a forwarded access is outstanding and high after reset.
- R5: A latched value from 0x1FFFF up to but not including 0x7FFFF blocks data-port accesses, with status code 1.
- R6: A latched value from 0x7FFFF up to but not including 0xFFFFF blocks data-port accesses, with status code 2.
- R7: A latched value of 0xFFFFF or above blocks data-port accesses, with status code 3.
- R8: A blocked data-port access raises `blk_stb` for one cycle, the cycle after acceptance, with `blk_code` set to the range code. It issues no bus request. A blocked read returns zero.
- R9: An access to any window offset other than 0x0 and 0x4, including a misaligned offset, reads as zero, leaves the address port unchanged and issues no bus request.
- R10: An access whose byte strobe is not 4'hF is dropped. A write leaves all state unchanged, a read returns zero, and no bus request or status strobe is produced.
- R11: Every read that is not forwarded is accepted while `io_ready` is high and raises `io_rvalid` in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Host access request |
| io_ready | output | 1 | Block can accept a host access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_offset | input | 5 | Byte offset inside the 32-byte window |
| io_strb | input | 4 | Byte strobes; only 4'hF is accepted |
| io_wdata | input | 32 | Host write data |
| io_rvalid | output | 1 | Host read data valid (one cycle) |
| io_rdata | output | 32 | Host read data |
| rb_valid | output | 1 | Register bus request valid |
| rb_ready | input | 1 | Register bus request accepted |
| rb_write | output | 1 | Register bus direction |
| rb_addr | output | 17 | Register bus offset |
| rb_wdata | output | 32 | Register bus write data |
| rb_rvalid | input | 1 | Register bus read response valid |
| rb_rdata | input | 32 | Register bus read response data |
| blk_stb | output | 1 | Blocked data-port access strobe |
| blk_code | output | 2 | Range code of the blocked access: 1 undefined, 2 flash, 3 unknown |

## Verification
The hardest cases to reach are the one-below and exact values at each range edge (0x1FFFE/0x1FFFF, 0x7FFFE/0x7FFFF, 0xFFFFE/0xFFFFF). At each edge, a forwarded access and a blocked one must differ only in a comparator result. The stimulus walks the address port across every edge and follows each setting with a data-port write and read. A bench responder raises an error on any bus request that was not predicted.

A second difficult case is a read response that arrives in the same cycle as the request handshake. The responder switches between a delayed-ready, late-response mode and a zero-wait mode that answers in the handshake cycle itself, so both completion paths of the back-end sequencer are exercised.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  // Range of the latched address; the numeric value is the status code.
  typedef enum logic [1:0] {
    RGN_REG     = 2'd0,
    RGN_UNDEF   = 2'd1,
    RGN_FLASH   = 2'd2,
    RGN_UNKNOWN = 2'd3
  } region_e;

  // Which port of the window a host access targets.
  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_DATA = 2'd1,
    PORT_NONE = 2'd2
  } port_e;

  // Back-end sequencer state.
  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_REQ  = 2'd1,
    BS_RESP = 2'd2
  } bus_state_e;

  localparam int unsigned NUM_LIMITS = 3;

endpackage

// File: rtl/iowin_decode.sv
module iowin_decode
  import iowin_pkg::*;
#(
  parameter int unsigned OFF_W     = 5,
  parameter int unsigned SW        = 4,
  parameter int unsigned ADDR_PORT = 0,
  parameter int unsigned DATA_PORT = 4
) (
  input  logic [OFF_W-1:0] offset,
  input  logic [SW-1:0]    strb,
  output port_e            port,
  output logic             full
);

  localparam logic [OFF_W-1:0] ADDR_OFF = OFF_W'(ADDR_PORT);
  localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(DATA_PORT);

  // Only a strobe covering the whole dword is a legal access.
  assign full = &strb;

  always_comb begin
    if (offset == ADDR_OFF) begin
      port = PORT_ADDR;
    end else if (offset == DATA_OFF) begin
      port = PORT_DATA;
    end else begin
      port = PORT_NONE;
    end
  end

endmodule

// File: rtl/iowin_classify.sv
module iowin_classify
  import iowin_pkg::*;
#(
  parameter int unsigned AW = 32,
  // Ascending boundaries: register/undefined, undefined/flash, flash/unknown.
  parameter logic [NUM_LIMITS-1:0][AW-1:0] LIMITS = {32'h000F_FFFF, 32'h0007_FFFF, 32'h0001_FFFF}
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);

  localparam int unsigned CW = $clog2(NUM_LIMITS + 1);

  logic [NUM_LIMITS-1:0] at_or_above;
  logic [CW-1:0]         level;

  // One comparator per boundary; the result is a thermometer code.
  for (genvar gi = 0; gi < NUM_LIMITS; gi++) begin : g_cmp
    assign at_or_above[gi] = (addr >= LIMITS[gi]);
  end

  always_comb begin
    level = '0;
    for (int i = 0; i < NUM_LIMITS; i++) begin
      level = level + CW'(at_or_above[i]);
    end
  end

  assign region = region_e'(level);

endmodule

// File: rtl/iowin_busfsm.sv
module iowin_busfsm
  import iowin_pkg::*;
#(
  parameter int unsigned RB_AW = 17,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic [RB_AW-1:0] start_addr,
  input  logic [DW-1:0]    start_wdata,
  output logic             busy,
  output logic             rd_fire,
  output logic [DW-1:0]    rd_data,
  output logic             rb_valid,
  input  logic             rb_ready,
  output logic             rb_write,
  output logic [RB_AW-1:0] rb_addr,
  output logic [DW-1:0]    rb_wdata,
  input  logic             rb_rvalid,
  input  logic [DW-1:0]    rb_rdata
);

  bus_state_e state_q;
  logic             wr_q;
  logic [RB_AW-1:0] addr_q;
  logic [DW-1:0]    wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BS_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        BS_IDLE: begin
          if (start) begin
            state_q <= BS_REQ;
            wr_q    <= start_wr;
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
          end
        end
        BS_REQ: begin
          if (rb_ready) begin
            if (wr_q || rb_rvalid) begin
              state_q <= BS_IDLE;
            end else begin
              state_q <= BS_RESP;
            end
          end
        end
        BS_RESP: begin
          if (rb_rvalid) begin
            state_q <= BS_IDLE;
          end
        end
        default: state_q <= BS_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != BS_IDLE);
  assign rb_valid = (state_q == BS_REQ);
  assign rb_write = wr_q;
  assign rb_addr  = addr_q;
  assign rb_wdata = wdata_q;

  // Read completion: response in the handshake cycle or in a later one.
  assign rd_fire = !wr_q && rb_rvalid &&
                   (((state_q == BS_REQ) && rb_ready) || (state_q == BS_RESP));
  assign rd_data = rb_rdata;

endmodule

// File: rtl/iowin_top.sv
module iowin_top
  import iowin_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned OFF_W       = 5,
  parameter int unsigned RB_AW       = 17,
  parameter int unsigned ADDR_PORT   = 0,
  parameter int unsigned DATA_PORT   = 4,
  parameter logic [31:0] VALID_LIMIT = 32'h0001_FFFF,
  parameter logic [31:0] UNDEF_LIMIT = 32'h0007_FFFF,
  parameter logic [31:0] FLASH_LIMIT = 32'h000F_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_valid,
  output logic             io_ready,
  input  logic             io_write,
  input  logic [OFF_W-1:0] io_offset,
  input  logic [DW/8-1:0]  io_strb,
  input  logic [DW-1:0]    io_wdata,
  output logic             io_rvalid,
  output logic [DW-1:0]    io_rdata,
  output logic             rb_valid,
  input  logic             rb_ready,
  output logic             rb_write,
  output logic [RB_AW-1:0] rb_addr,
  output logic [DW-1:0]    rb_wdata,
  input  logic             rb_rvalid,
  input  logic [DW-1:0]    rb_rdata,
  output logic             blk_stb,
  output logic [1:0]       blk_code
);

  localparam int unsigned SW = DW / 8;

  port_e         port;
  logic          full;
  region_e       region;
  logic          accept;
  logic          fwd_start;
  logic          busy;
  logic          rd_fire;
  logic [DW-1:0] rd_data;

  logic [DW-1:0] addr_q;
  logic          rvalid_q;
  logic [DW-1:0] rdata_q;
  logic          blk_q;
  logic [1:0]    code_q;

  iowin_decode #(
    .OFF_W    (OFF_W),
    .SW       (SW),
    .ADDR_PORT(ADDR_PORT),
    .DATA_PORT(DATA_PORT)
  ) u_decode (
    .offset(io_offset),
    .strb  (io_strb),
    .port  (port),
    .full  (full)
  );

  iowin_classify #(
    .AW    (DW),
    .LIMITS({FLASH_LIMIT, UNDEF_LIMIT, VALID_LIMIT})
  ) u_classify (
    .addr  (addr_q),
    .region(region)
  );

  assign io_ready  = !busy;
  assign accept    = io_valid && io_ready;
  assign fwd_start = accept && full && (port == PORT_DATA) && (region == RGN_REG);

  iowin_busfsm #(
    .RB_AW(RB_AW),
    .DW   (DW)
  ) u_busfsm (
    .clk        (clk),
    .rst        (rst),
    .start      (fwd_start),
    .start_wr   (io_write),
    .start_addr (addr_q[RB_AW-1:0]),
    .start_wdata(io_wdata),
    .busy       (busy),
    .rd_fire    (rd_fire),
    .rd_data    (rd_data),
    .rb_valid   (rb_valid),
    .rb_ready   (rb_ready),
    .rb_write   (rb_write),
    .rb_addr    (rb_addr),
    .rb_wdata   (rb_wdata),
    .rb_rvalid  (rb_rvalid),
    .rb_rdata   (rb_rdata)
  );

  // Host-side registers: address latch, read return and status strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      blk_q    <= 1'b0;
      code_q   <= 2'd0;
    end else begin
      rvalid_q <= 1'b0;
      blk_q    <= 1'b0;
      if (rd_fire) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_data;
      end
      if (accept) begin
        if (!full) begin
          if (!io_write) begin
            rvalid_q <= 1'b1;
            rdata_q  <= '0;
          end
        end else begin
          unique case (port)
            PORT_ADDR: begin
              if (io_write) begin
                addr_q <= io_wdata;
              end else begin
                rvalid_q <= 1'b1;
                rdata_q  <= addr_q;
              end
            end
            PORT_DATA: begin
              if (region != RGN_REG) begin
                blk_q  <= 1'b1;
                code_q <= 2'(region);
                if (!io_write) begin
                  rvalid_q <= 1'b1;
                  rdata_q  <= '0;
                end
              end
            end
            default: begin
              if (!io_write) begin
                rvalid_q <= 1'b1;
                rdata_q  <= '0;
              end
            end
          endcase
        end
      end
    end
  end

  assign io_rvalid = rvalid_q;
  assign io_rdata  = rdata_q;
  assign blk_stb   = blk_q;
  assign blk_code  = code_q;

endmodule

// File: rtl/iowin_chk.sv
module iowin_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned OFF_W = 5,
  parameter int unsigned RB_AW = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             io_valid,
  input logic             io_ready,
  input logic             io_write,
  input logic [OFF_W-1:0] io_offset,
  input logic [DW/8-1:0]  io_strb,
  input logic             io_rvalid,
  input logic             rb_valid,
  input logic             rb_ready,
  input logic             rb_write,
  input logic [RB_AW-1:0] rb_addr,
  input logic [DW-1:0]    rb_wdata,
  input logic             blk_stb,
  input logic [1:0]       blk_code
);

  // R4
  rb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rb_valid && !rb_ready |=> rb_valid && $stable(rb_addr) && $stable(rb_write) && $stable(rb_wdata));

  // R4
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rb_valid |-> !io_ready);

  // R3
  rvalid_wait_chk: assert property (@(posedge clk) disable iff (rst)
    rb_valid |-> !io_rvalid);

  // R2
  fwd_range_chk: assert property (@(posedge clk) disable iff (rst)
    rb_valid |-> ({{(32-RB_AW){1'b0}}, rb_addr} < 32'h0001_FFFF));

  // R8
  blk_code_chk: assert property (@(posedge clk) disable iff (rst)
    blk_stb |-> (blk_code != 2'd0) && !rb_valid);

  // R11
  addr_rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    io_valid && io_ready && !io_write && (io_offset == '0) && (&io_strb) |=> io_rvalid);

  // R10
  partial_drop_chk: assert property (@(posedge clk) disable iff (rst)
    io_valid && io_ready && !(&io_strb) |=> !blk_stb && !rb_valid);

endmodule

bind iowin_top iowin_chk #(
  .DW   (DW),
  .OFF_W(OFF_W),
  .RB_AW(RB_AW)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .io_valid (io_valid),
  .io_ready (io_ready),
  .io_write (io_write),
  .io_offset(io_offset),
  .io_strb  (io_strb),
  .io_rvalid(io_rvalid),
  .rb_valid (rb_valid),
  .rb_ready (rb_ready),
  .rb_write (rb_write),
  .rb_addr  (rb_addr),
  .rb_wdata (rb_wdata),
  .blk_stb  (blk_stb),
  .blk_code (blk_code)
);

// File: tb/iowin_top_tb_top.sv
`timescale 1ns/1ps
module iowin_top_tb_top;

  localparam int DW    = 32;
  localparam int OFF_W = 5;
  localparam int RB_AW = 17;

  logic             clk = 1'b0;
  logic             rst;
  logic             io_valid;
  logic             io_ready;
  logic             io_write;
  logic [OFF_W-1:0] io_offset;
  logic [3:0]       io_strb;
  logic [DW-1:0]    io_wdata;
  logic             io_rvalid;
  logic [DW-1:0]    io_rdata;
  logic             rb_valid;
  logic             rb_ready;
  logic             rb_write;
  logic [RB_AW-1:0] rb_addr;
  logic [DW-1:0]    rb_wdata;
  logic             rb_rvalid;
  logic [DW-1:0]    rb_rdata;
  logic             blk_stb;
  logic [1:0]       blk_code;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Bench state
  logic [31:0] cur_addr;
  logic [31:0] shadow [int];
  logic [31:0] model  [int];
  logic [64:0] bus_q  [$];
  logic [31:0] rd_q   [$];
  string       rd_tag [$];
  bit          fast_mode = 0;
  int          ready_delay = 2;

  always #2 clk = ~clk;

  iowin_top dut_i (
    .clk      (clk),
    .rst      (rst),
    .io_valid (io_valid),
    .io_ready (io_ready),
    .io_write (io_write),
    .io_offset(io_offset),
    .io_strb  (io_strb),
    .io_wdata (io_wdata),
    .io_rvalid(io_rvalid),
    .io_rdata (io_rdata),
    .rb_valid (rb_valid),
    .rb_ready (rb_ready),
    .rb_write (rb_write),
    .rb_addr  (rb_addr),
    .rb_wdata (rb_wdata),
    .rb_rvalid(rb_rvalid),
    .rb_rdata (rb_rdata),
    .blk_stb  (blk_stb),
    .blk_code (blk_code)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Register bus responder; also compares each request with the prediction.
  initial begin
    int   wait_cnt = 0;
    bit   pend = 0;
    int   pend_cnt = 0;
    int   pend_addr = 0;
    rb_ready  = 1'b0;
    rb_rvalid = 1'b0;
    rb_rdata  = '0;
    forever begin
      @(negedge clk);
      rb_ready  = 1'b0;
      rb_rvalid = 1'b0;
      if (pend) begin
        if (pend_cnt >= 2) begin
          rb_rvalid = 1'b1;
          rb_rdata  = model.exists(pend_addr) ? model[pend_addr] : 32'h0;
          pend = 0;
        end else begin
          pend_cnt++;
        end
      end else if (rb_valid) begin
        if (!fast_mode && wait_cnt < ready_delay) begin
          wait_cnt++;
          // R4: host side must be stalled while the request waits
          check(!io_ready, "R4 io_ready while request pending", 64'(io_ready), 64'd0);
        end else begin
          wait_cnt = 0;
          rb_ready = 1'b1;
          if (bus_q.size() == 0) begin
            check(1'b0, "R2/R8/R10 unexpected bus request", {31'd0, rb_write, 15'd0, rb_addr}, 64'd0);
          end else begin
            logic [64:0] e;
            e = bus_q.pop_front();
            check({rb_write, 15'd0, rb_addr, rb_write ? rb_wdata : 32'd0} == e, "R2 bus request",
                  64'({rb_write, 15'd0, rb_addr, rb_wdata}), 64'(e));
          end
          if (rb_write) begin
            model[int'(rb_addr)] = rb_wdata;
          end else if (fast_mode) begin
            rb_rvalid = 1'b1;
            rb_rdata  = model.exists(int'(rb_addr)) ? model[int'(rb_addr)] : 32'h0;
          end else begin
            pend = 1;
            pend_cnt = 0;
            pend_addr = int'(rb_addr);
          end
        end
      end
    end
  end

  // Monitor for forwarded read returns.
  initial begin
    forever begin
      @(negedge clk);
      if (io_rvalid && rd_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = rd_q.pop_front();
        t = rd_tag.pop_front();
        check(io_rdata == e, t, 64'(io_rdata), 64'(e));
      end
    end
  end

  // One host access; checks local read data and status strobe right after acceptance.
  task automatic io_acc(input bit wr, input logic [4:0] off, input logic [3:0] strb,
                        input logic [31:0] wd, input bit local_rd, input logic [31:0] exp_rd,
                        input logic [1:0] exp_code, input string tag);
    @(negedge clk);
    while (!io_ready) @(negedge clk);
    io_valid  = 1'b1;
    io_write  = wr;
    io_offset = off;
    io_strb   = strb;
    io_wdata  = wd;
    @(negedge clk);
    io_valid = 1'b0;
    if (local_rd) begin
      // R11
      check(io_rvalid == 1'b1, {tag, " R11 rvalid latency"}, 64'(io_rvalid), 64'd1);
      check(io_rdata == exp_rd, tag, 64'(io_rdata), 64'(exp_rd));
    end
    check(blk_stb == (exp_code != 0), {tag, " R8 blk_stb"}, 64'(blk_stb), 64'(exp_code != 0));
    if (exp_code != 0)
      check(blk_code == exp_code, {tag, " blk_code"}, 64'(blk_code), 64'(exp_code));
  endtask

  function automatic logic [1:0] range_of(input logic [31:0] a);
    if (a < 32'h0001_FFFF) return 2'd0;
    if (a < 32'h0007_FFFF) return 2'd1;
    if (a < 32'h000F_FFFF) return 2'd2;
    return 2'd3;
  endfunction

  task automatic set_addr(input logic [31:0] v);
    cur_addr = v;
    io_acc(1, 5'h0, 4'hF, v, 0, 0, 0, "R1 addr write");
  endtask

  task automatic data_wr(input logic [31:0] v, input string tag);
    logic [1:0] c;
    c = range_of(cur_addr);
    if (c == 0) begin
      bus_q.push_back({1'b1, 15'd0, cur_addr[16:0], v});
      shadow[int'(cur_addr)] = v;
    end
    io_acc(1, 5'h4, 4'hF, v, 0, 0, c, tag);
  endtask

  task automatic data_rd(input string tag);
    logic [1:0] c;
    c = range_of(cur_addr);
    if (c == 0) begin
      bus_q.push_back({1'b0, 15'd0, cur_addr[16:0], 32'd0});
      io_acc(0, 5'h4, 4'hF, 0, 0, 0, 0, tag);
      rd_q.push_back(shadow.exists(int'(cur_addr)) ? shadow[int'(cur_addr)] : 32'h0);
      rd_tag.push_back({tag, " R3 forwarded read"});
    end else begin
      io_acc(0, 5'h4, 4'hF, 0, 1, 32'h0, c, {tag, " R8 blocked read zero"});
    end
  endtask

  task automatic edge_pair(input logic [31:0] a, input string tag);
    set_addr(a);
    data_wr(32'h5000_0000 ^ a, tag);
    data_rd(tag);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    io_valid = 1'b0; io_write = 1'b0; io_offset = '0; io_strb = '0; io_wdata = '0;
    cur_addr = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R4 reset state
    check(io_ready == 1'b1, "R4 io_ready after reset", 64'(io_ready), 64'd1);
    check(rb_valid == 1'b0 && blk_stb == 1'b0 && io_rvalid == 1'b0, "R1 idle outputs after reset",
          64'({rb_valid, blk_stb, io_rvalid}), 64'd0);
    io_acc(0, 5'h0, 4'hF, 0, 1, 32'h0, 0, "R1 addr reset value");

    // R1 full 32-bit store; value lies in unknown range (R7)
    set_addr(32'hDEAD_BEEF);
    io_acc(0, 5'h0, 4'hF, 0, 1, 32'hDEAD_BEEF, 0, "R1 addr readback");
    data_wr(32'h1111_2222, "R7 blocked write");
    data_rd("R7");

    // R2/R3 forwarded with delayed ready and late response
    set_addr(32'h0000_0010);
    data_wr(32'hA5A5_0001, "R2 write");
    data_rd("R2");
    set_addr(32'h0000_0014);
    data_wr(32'h0BAD_F00D, "R2 write second");
    data_rd("R2 second");

    // R3 zero-wait, response in handshake cycle; R2 upper edge
    fast_mode = 1;
    edge_pair(32'h0001_FFFE, "R2 edge");
    set_addr(32'h0000_0010);
    data_rd("R3 fast");
    fast_mode = 0;
    ready_delay = 0;

    // Range edges
    edge_pair(32'h0001_FFFF, "R5 low edge");
    edge_pair(32'h0007_FFFE, "R5 high edge");
    edge_pair(32'h0007_FFFF, "R6 low edge");
    edge_pair(32'h000F_FFFE, "R6 high edge");
    edge_pair(32'h000F_FFFF, "R7 low edge");
    edge_pair(32'hFFFF_FFFF, "R7 top");

    // R8: blocked writes left register 0x10 untouched
    ready_delay = 3;
    set_addr(32'h0000_0010);
    data_rd("R8 value after blocked writes");

    // R9 other offsets
    set_addr(32'h0000_0123);
    io_acc(0, 5'h08, 4'hF, 0, 1, 32'h0, 0, "R9 offset 0x8 read");
    io_acc(1, 5'h08, 4'hF, 32'hFFFF_0000, 0, 0, 0, "R9 offset 0x8 write");
    io_acc(1, 5'h1C, 4'hF, 32'h0000_7777, 0, 0, 0, "R9 offset 0x1C write");
    io_acc(0, 5'h0, 4'hF, 0, 1, 32'h0000_0123, 0, "R9 addr unchanged");
    io_acc(0, 5'h1C, 4'hF, 0, 1, 32'h0, 0, "R9 offset 0x1C read");
    io_acc(0, 5'h05, 4'hF, 0, 1, 32'h0, 0, "R9 misaligned read");

    // R10 partial strobes
    io_acc(1, 5'h0, 4'h3, 32'h0000_0010, 0, 0, 0, "R10 partial addr write");
    io_acc(0, 5'h0, 4'hF, 0, 1, 32'h0000_0123, 0, "R10 addr unchanged");
    set_addr(32'h0000_0010);
    io_acc(1, 5'h4, 4'h7, 32'hCAFE_CAFE, 0, 0, 0, "R10 partial data write");
    io_acc(0, 5'h4, 4'hE, 0, 1, 32'h0, 0, "R10 partial data read");
    set_addr(32'h0007_FFFF);
    io_acc(1, 5'h4, 4'h1, 32'h1, 0, 0, 0, "R10 partial blocked write");
    set_addr(32'h0000_0010);
    data_rd("R10 register unchanged");

    // Drain
    begin
      int n = 0;
      while ((rd_q.size() != 0 || bus_q.size() != 0) && n < 200) begin
        @(negedge clk);
        n++;
      end
    end
    repeat (4) @(negedge clk);
    check(rd_q.size() == 0, "R3 missing read returns", 64'(rd_q.size()), 64'd0);
    check(bus_q.size() == 0, "R2 missing bus requests", 64'(bus_q.size()), 64'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule